// File: doc/BRIEF.md
# Flash Converter Thermometer-to-Binary Encoder

This block takes the comparator word of a parallel (flash) analog-to-digital converter and turns it into a binary sample. For an N-bit result the converter has 2^N-1 comparators plus one extra over-range comparator. A comparator bit reads one when its reference tap sits above the analog input. With bit 0 at the lowest tap, a clean input therefore shows zeros at the bottom of the word and ones above them.

First, every neighbouring pair of comparator bits is gated so that only the zero-to-one boundary raises a mark. The block keeps the highest such mark, which gives a one-hot word, and encodes that word to binary. When the over-range comparator is set, the result saturates at all ones and a separate flag goes high. The comparator word is registered when it arrives and the result is registered on the way out, so every sample appears two clock cycles after it was presented. An optional valid bit travels alongside the sample.

Top module: `flash_therm_enc`

## Requirements
- R1: The comparator input is 2^NBITS-1 bits wide, with bit 0 at the lowest tap. A clean thermometer word with k zero bits at the bottom (0 <= k <= 2^NBITS-1) and ones above gives code k.
- R2: A comparator word of all ones, meaning the input is below every tap, gives code 0 when over-range is low.
- R3: A comparator word of all zeros gives code 2^NBITS-1 and over-range flag 0 when over-range is low.
- R4: When the over-range input is 1, the code is all ones and the over-range flag is 1, whatever the comparator word holds. When the over-range input is 0, the flag is 0.
- R5: A transition at position k (1 <= k <= 2^NBITS-1) exists when bit k-1 is 0 and bit k is 1, with the bit above the top tap taken as 1. If several transitions are present, the code equals the highest k. If there is no transition, the code is 0.
- R6: Code and over-range flag appear exactly two rising clock edges after the inputs are sampled, and a new sample is accepted on every cycle.
- R7: The valid output repeats the valid input with the same two-cycle latency. The valid input has no effect on the code.
- R8: A synchronous active-high reset clears the code, the over-range flag and the valid output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_i | input | 2^NBITS-1 | Comparator word, bit 0 at the lowest tap, 1 = tap above input |
| ovr_i | input | 1 | Over-range comparator, 1 = input above the top of the range |
| vld_i | input | 1 | Sample valid in |
| code_o | output | NBITS | Binary sample |
| over_o | output | 1 | Over-range flag |
| vld_o | output | 1 | Sample valid out |

## Verification
The assertions treat every input as a registered, settled value at each rising edge. They only judge outputs once two edges have passed since reset, so that both pipeline stages hold real samples. The saturation and end-of-scale properties assume that the all-ones and all-zeros words carry no other meaning. The bench changes inputs only on falling edges and sweeps every comparator word with the over-range bit both low and high, so bubbled words are covered as well as clean ones. It also streams back-to-back samples with a changing valid bit to pin down the latency.

// File: rtl/ftenc_pkg.sv
package ftenc_pkg;
  function automatic int tap_count(input int nbits);
    return (1 << nbits) - 1;
  endfunction
endpackage

// File: rtl/ftenc_front.sv
module ftenc_front #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cmp_i,
  input  logic         ovr_i,
  input  logic         vld_i,
  output logic [W-1:0] cmp_q,
  output logic         ovr_q,
  output logic         vld_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= '1;
      ovr_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      cmp_q <= cmp_i;
      ovr_q <= ovr_i;
      vld_q <= vld_i;
    end
  end
endmodule

// File: rtl/ftenc_mark.sv
// Adjacent-pair gating: mark_n[j] is low only where bit j is 0 and the bit
// above it is 1 (the bit above the top tap is taken as 1).
module ftenc_mark #(
  parameter int W = 15
) (
  input  logic [W-1:0] therm,
  output logic [W-1:0] mark_n
);
  for (genvar j = 0; j < W; j++) begin : g_pair
    if (j == W - 1) begin : g_top
      assign mark_n[j] = ~(~therm[j] & 1'b1);
    end else begin : g_mid
      assign mark_n[j] = ~(~therm[j] & therm[j+1]);
    end
  end
endmodule

// File: rtl/ftenc_pick.sv
// Keeps only the highest active mark, giving a one-hot (or empty) word.
module ftenc_pick #(
  parameter int W = 15
) (
  input  logic [W-1:0] act,
  output logic [W-1:0] onehot
);
  logic [W:0] above;
  assign above[W] = 1'b0;
  for (genvar j = W - 1; j >= 0; j--) begin : g_sfx
    assign above[j]  = above[j+1] | act[j];
    assign onehot[j] = act[j] & ~above[j+1];
  end
endmodule

// File: rtl/ftenc_encode.sv
// One-hot position j stands for code j+1; an empty word encodes to 0.
module ftenc_encode #(
  parameter int W = 15,
  parameter int N = 4
) (
  input  logic [W-1:0] onehot,
  output logic [N-1:0] bin
);
  always_comb begin
    bin = '0;
    for (int b = 0; b < N; b++) begin
      for (int j = 0; j < W; j++) begin
        if ((((j + 1) >> b) % 2) == 1) bin[b] = bin[b] | onehot[j];
      end
    end
  end
endmodule

// File: rtl/flash_therm_enc.sv
module flash_therm_enc #(
  parameter int NBITS = 4,
  localparam int TAPS = ftenc_pkg::tap_count(NBITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TAPS-1:0]  cmp_i,
  input  logic             ovr_i,
  input  logic             vld_i,
  output logic [NBITS-1:0] code_o,
  output logic             over_o,
  output logic             vld_o
);
  logic [TAPS-1:0]  cmp_q;
  logic             ovr_q;
  logic             vld_q;
  logic [TAPS-1:0]  mark_n;
  logic [TAPS-1:0]  onehot;
  logic [NBITS-1:0] bin;
  logic [NBITS-1:0] code_d;

  ftenc_front #(.W(TAPS)) u_front (
    .clk(clk), .rst(rst), .cmp_i(cmp_i), .ovr_i(ovr_i), .vld_i(vld_i),
    .cmp_q(cmp_q), .ovr_q(ovr_q), .vld_q(vld_q)
  );

  ftenc_mark #(.W(TAPS)) u_mark (.therm(cmp_q), .mark_n(mark_n));

  ftenc_pick #(.W(TAPS)) u_pick (.act(~mark_n), .onehot(onehot));

  ftenc_encode #(.W(TAPS), .N(NBITS)) u_enc (.onehot(onehot), .bin(bin));

  assign code_d = ovr_q ? '1 : bin;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_o <= '0;
      over_o <= 1'b0;
      vld_o  <= 1'b0;
    end else begin
      code_o <= code_d;
      over_o <= ovr_q;
      vld_o  <= vld_q;
    end
  end
endmodule

// File: rtl/ftenc_chk.sv
module ftenc_chk #(
  parameter int NBITS = 4,
  localparam int TAPS = ftenc_pkg::tap_count(NBITS)
) (
  input logic             clk,
  input logic             rst,
  input logic [TAPS-1:0]  cmp_i,
  input logic             ovr_i,
  input logic             vld_i,
  input logic [NBITS-1:0] code_o,
  input logic             over_o,
  input logic             vld_o
);
  logic [1:0] cyc_q;
  always_ff @(posedge clk) begin
    if (rst) cyc_q <= 2'd0;
    else if (cyc_q != 2'd2) cyc_q <= cyc_q + 2'd1;
  end

  p_valid_latency_r7: assert property (@(posedge clk) disable iff (rst)
    (cyc_q == 2'd2) |-> (vld_o == $past(vld_i, 2)));

  p_over_latency_r6: assert property (@(posedge clk) disable iff (rst)
    (cyc_q == 2'd2) |-> (over_o == $past(ovr_i, 2)));

  p_over_saturates_r4: assert property (@(posedge clk) disable iff (rst)
    over_o |-> (code_o == {NBITS{1'b1}}));

  p_below_all_zero_r2: assert property (@(posedge clk) disable iff (rst)
    ((cyc_q == 2'd2) && ($past(cmp_i, 2) == {TAPS{1'b1}}) && !$past(ovr_i, 2))
      |-> (code_o == '0));

  p_full_scale_r3: assert property (@(posedge clk) disable iff (rst)
    ((cyc_q == 2'd2) && ($past(cmp_i, 2) == '0) && !$past(ovr_i, 2))
      |-> (code_o == NBITS'(TAPS) && !over_o));
endmodule

bind flash_therm_enc ftenc_chk #(.NBITS(NBITS)) u_chk (
  .clk(clk), .rst(rst), .cmp_i(cmp_i), .ovr_i(ovr_i), .vld_i(vld_i),
  .code_o(code_o), .over_o(over_o), .vld_o(vld_o)
);

// File: tb/flash_therm_enc_tb.sv
module flash_therm_enc_tb;
  localparam int N = 3;
  localparam int M = (1 << N) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [M-1:0] cmp_i = '1;
  logic         ovr_i = 1'b0;
  logic         vld_i = 1'b0;
  logic [N-1:0] code_o;
  logic         over_o;
  logic         vld_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  flash_therm_enc #(.NBITS(N)) u_dut (
    .clk(clk), .rst(rst), .cmp_i(cmp_i), .ovr_i(ovr_i), .vld_i(vld_i),
    .code_o(code_o), .over_o(over_o), .vld_o(vld_o)
  );

  function automatic int exp_code(input logic [M-1:0] t, input logic o);
    int r = 0;
    if (o) return M;
    for (int k = 1; k <= M; k++) begin
      logic hi;
      hi = (k == M) ? 1'b1 : t[k];
      if (!t[k-1] && hi) r = k;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic apply_and_check(input logic [M-1:0] t, input logic o, input string req);
    int e;
    @(negedge clk);
    cmp_i = t; ovr_i = o; vld_i = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    e = exp_code(t, o);
    check(int'(code_o) == e, req, int'(code_o), e);
    check(over_o == o, "R4 flag", int'(over_o), int'(o));
  endtask

  initial begin
    logic [M-1:0] hist_c [0:31];
    logic         hist_o [0:31];
    logic         hist_v [0:31];
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: reset state
    check(code_o == '0 && !over_o && !vld_o, "R8", int'({code_o, over_o, vld_o}), 0);
    rst = 1'b0;

    // R1: clean thermometer words
    for (int k = 0; k <= M; k++) begin
      logic [M-1:0] t;
      t = ~((M'(1) << k) - M'(1));
      if (k == M) t = '0;
      apply_and_check(t, 1'b0, "R1");
    end
    apply_and_check('1, 1'b0, "R2");
    apply_and_check('0, 1'b0, "R3");
    apply_and_check(7'b0110101, 1'b1, "R4");
    apply_and_check(7'b0101011, 1'b0, "R5 bubble");

    // R5 / R4: full sweep of all words with over-range low and high
    for (int p = 0; p < (1 << (M + 1)); p++) begin
      apply_and_check(M'(p), p[M], "R5 sweep");
    end

    // R6 / R7: streaming back-to-back samples
    for (int c = 0; c < 32; c++) begin
      @(negedge clk);
      if (c >= 2) begin
        int e;
        e = exp_code(hist_c[c-2], hist_o[c-2]);
        check(int'(code_o) == e, "R6", int'(code_o), e);
        check(vld_o == hist_v[c-2], "R7", int'(vld_o), int'(hist_v[c-2]));
      end
      hist_c[c] = M'((c * 37 + 11) % 128);
      hist_o[c] = (c % 7) == 3;
      hist_v[c] = (c % 3) != 1;
      cmp_i = hist_c[c]; ovr_i = hist_o[c]; vld_i = hist_v[c];
    end

    // R8: reset mid-stream clears outputs
    @(negedge clk);
    cmp_i = '0; ovr_i = 1'b1; vld_i = 1'b1; rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(code_o == '0 && !over_o && !vld_o, "R8 mid", int'({code_o, over_o, vld_o}), 0);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule